// File: doc/BRIEF.md
# Mod-3 Channel Hash Generator

This block spreads real addresses evenly over three memory controllers. It takes three bit pairs from the real address and the two top port-address bits, and it builds a 3-bit one-hot code. That code names the channel for the access. The block does no division. It starts from a one-hot form of the lowest pair. Each later pair, and then the port-address bits, rotates that code by 0 to 3 single steps.

In the one-hot form, 3'b100 means residue 0, 3'b010 means residue 1 and 3'b001 means residue 2. One right step therefore adds one modulo 3, and one left step subtracts one. A parameter picks the rotation direction for the chained stages. The result and a valid flag are registered, so a strobed input gives its hash one clock later.

Top module: `mod3_chan_hash`

## Requirements
- R1: The first stage encodes the address pair at bit positions [16:15] as 3'b100 shifted right by (value mod 3). Values 0, 1, 2 and 3 give 100, 010, 001 and 100.
- R2: With ROT_LEFT=0 (the default), the hash is the R1 code of residue (a + b + c + m) mod 3. Here a = addr[16:15], b = addr[18:17], c = addr[20:19] and m = in_msb[1:0]. Each right step maps 100 to 010, 010 to 001 and 001 to 100.
- R3: out_valid equals in_valid as sampled at the previous rising clock edge. A hash computed from inputs strobed at one edge appears on out_hash after that edge.
- R4: A synchronous active-low reset drives out_hash to 3'b100 and out_valid to 0.
- R5: While in_valid is low, out_hash holds its last value, whatever the address and port-address inputs do.
- R6: Whenever out_valid is high, out_hash has exactly one bit set.
- R7: Address bits outside [20:15] have no effect on out_hash.
- R8: With ROT_LEFT=1, every chained stage rotates left instead. The hash is then the R1 code of residue (a - b - c - m) mod 3. Each left step maps 100 to 001, 001 to 010 and 010 to 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe; the hash register loads only when it is high |
| in_addr | input | ADDR_W (64) | Real address; only bits [20:15] are used |
| in_msb | input | 2 | Two most significant port-address bits m[1:0] |
| out_valid | output | 1 | Registered copy of in_valid |
| out_hash | output | 3 | Registered one-hot channel hash |

## Verification
On every clock cycle, the assertions check four things. The hash must be one-hot whenever it is valid. The valid flag must follow the strobe by one cycle. The hash must hold while no strobe is present. Each strobed hash must equal the residue of the sampled bit pairs, summed or subtracted according to the direction parameter. The bench sweeps all 256 combinations of the three address pairs and the port-address bits through both direction variants, with changing junk in the unused address bits. Only those scenarios can show the reset value and that the unused bits are ignored. They also show the exact code for a pair value of 3 and that the code holds across idle cycles with changing inputs.

// File: rtl/mch_pkg.sv
// Package: shared one-hot residue type and single-step rotations.
// Assumes codes are one-hot; 3'b100 stands for residue zero.
package mch_pkg;
    typedef logic [2:0] b3_t;

    localparam b3_t B3_RES0 = 3'b100;

    // One right step: bits [2:1] move down, bit 0 wraps into bit 2.
    function automatic b3_t b3_rstep(input b3_t c);
        return {c[0], c[2:1]};
    endfunction

    // One left step: bits [1:0] move up, bit 2 wraps into bit 0.
    function automatic b3_t b3_lstep(input b3_t c);
        return {c[1:0], c[2]};
    endfunction
endpackage

// File: rtl/mch_encode.sv
// Module: mch_encode
// Turns a 2-bit value into its one-hot residue code (3'b100 >> (v mod 3)).
// Assumes nothing beyond a 2-bit input; purely combinational.
module mch_encode
    import mch_pkg::*;
(
    input  logic [1:0] val,
    output b3_t        code
);
    // Map each value to its residue code; 3 folds back to residue zero.
    always_comb begin
        unique case (val)
            2'd0:    code = 3'b100;
            2'd1:    code = 3'b010;
            2'd2:    code = 3'b001;
            default: code = 3'b100;
        endcase
    end
endmodule

// File: rtl/mch_rotate.sv
// Module: mch_rotate
// Rotates a one-hot residue code by a count of 0..3 single steps.
// ROT_LEFT picks the direction at elaboration. Assumes a one-hot input.
module mch_rotate
    import mch_pkg::*;
#(
    parameter bit ROT_LEFT = 1'b0
) (
    input  b3_t        code_in,
    input  logic [1:0] count,
    output b3_t        code_out
);
    b3_t step1, step2, step3;

    generate
        if (ROT_LEFT) begin : g_left
            // Chain of left single steps.
            always_comb begin
                step1 = b3_lstep(code_in);
                step2 = b3_lstep(step1);
                step3 = b3_lstep(step2);
            end
        end else begin : g_right
            // Chain of right single steps.
            always_comb begin
                step1 = b3_rstep(code_in);
                step2 = b3_rstep(step1);
                step3 = b3_rstep(step2);
            end
        end
    endgenerate

    // Choose the tap that matches the requested step count.
    always_comb begin
        unique case (count)
            2'd0:    code_out = code_in;
            2'd1:    code_out = step1;
            2'd2:    code_out = step2;
            default: code_out = step3;
        endcase
    end
endmodule

// File: rtl/mod3_chan_hash.sv
// Module: mod3_chan_hash
// Computes the 3-channel one-hot hash from three address bit pairs and the two
// top port-address bits, then registers it with a valid flag (1 cycle latency).
// Assumes PAIR_LSB locates the first pair; the next pairs follow at +2 and +4.
module mod3_chan_hash
    import mch_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PAIR_LSB = 15,
    parameter bit ROT_LEFT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_msb,
    output logic              out_valid,
    output logic [2:0]        out_hash
);
    localparam int N_ROT = 3;

    b3_t        chain [N_ROT+1];
    logic [1:0] rot_cnt [N_ROT];

    // Gather the rotate counts: two upper address pairs, then port-address bits.
    always_comb begin
        rot_cnt[0] = in_addr[PAIR_LSB+3 -: 2];
        rot_cnt[1] = in_addr[PAIR_LSB+5 -: 2];
        rot_cnt[2] = in_msb;
    end

    mch_encode u_enc (
        .val  (in_addr[PAIR_LSB+1 -: 2]),
        .code (chain[0])
    );

    genvar gi;
    generate
        for (gi = 0; gi < N_ROT; gi++) begin : g_stage
            mch_rotate #(.ROT_LEFT(ROT_LEFT)) u_rot (
                .code_in  (chain[gi]),
                .count    (rot_cnt[gi]),
                .code_out (chain[gi+1])
            );
        end
    endgenerate

    // Output register: load the hash on a strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_hash  <= B3_RES0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_hash <= chain[N_ROT];
            end
        end
    end
endmodule

// File: rtl/mch_hash_chk.sv
// Module: mch_hash_chk
// Assertion checker bound to mod3_chan_hash. It checks the hash against a
// residue sum or difference of the sampled pairs. Assumes rst_n is low at start.
module mch_hash_chk #(
    parameter int ADDR_W   = 64,
    parameter int PAIR_LSB = 15,
    parameter bit ROT_LEFT = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic [1:0]        in_msb,
    input logic              out_valid,
    input logic [2:0]        out_hash
);
    // Residue from the pairs, as arithmetic on the values.
    function automatic logic [2:0] exp_code(input logic [1:0] a, input logic [1:0] b,
                                            input logic [1:0] c, input logic [1:0] m);
        int r;
        if (ROT_LEFT) r = (int'(a) + 9 - int'(b) - int'(c) - int'(m)) % 3;
        else          r = (int'(a) + int'(b) + int'(c) + int'(m)) % 3;
        return 3'b100 >> r;
    endfunction

    // R6: a valid hash is exactly one-hot.
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_hash) == 1));

    // R3: valid follows the strobe by one cycle.
    a_r3_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r3_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: no strobe, no change of hash.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_hash));

    // R2 / R8: strobed hash equals the residue of the sampled pairs.
    a_r2_residue: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_hash == exp_code($past(in_addr[PAIR_LSB+1 -: 2]),
                                           $past(in_addr[PAIR_LSB+3 -: 2]),
                                           $past(in_addr[PAIR_LSB+5 -: 2]),
                                           $past(in_msb))));
endmodule

bind mod3_chan_hash mch_hash_chk #(
    .ADDR_W   (ADDR_W),
    .PAIR_LSB (PAIR_LSB),
    .ROT_LEFT (ROT_LEFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .in_msb    (in_msb),
    .out_valid (out_valid),
    .out_hash  (out_hash)
);

// File: tb/mod3_chan_hash_bench.sv
// Bench: sweeps all 256 pair combinations through a right- and a left-rotating
// instance, with junk in the unused address bits, and checks reset and hold.
module mod3_chan_hash_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [1:0]        in_msb = 2'd0;
    logic              vr, vl;
    logic [2:0]        hr, hl;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mod3_chan_hash #(.ADDR_W(ADDR_W), .PAIR_LSB(15), .ROT_LEFT(1'b0)) u_mod3_chan_hash (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_msb(in_msb), .out_valid(vr), .out_hash(hr));

    mod3_chan_hash #(.ADDR_W(ADDR_W), .PAIR_LSB(15), .ROT_LEFT(1'b1)) u_mod3_chan_hash_left (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_msb(in_msb), .out_valid(vl), .out_hash(hl));

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one strobed input at a falling edge and sample at the next falling edge.
    task automatic apply(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c,
                         input logic [1:0] m, input logic [63:0] junk, input string req);
        int rs, rl;
        @(negedge clk);
        in_addr  = (junk & ~(64'h3F << 15)) | (64'(a) << 15) | (64'(b) << 17) | (64'(c) << 19);
        in_msb   = m;
        in_valid = 1'b1;
        @(negedge clk);
        rs = (a + b + c + m) % 3;
        rl = (a + 9 - b - c - m) % 3;
        check(req, hr, 3'b100 >> rs);
        check("R8", hl, 3'b100 >> rl);
        check("R3", {2'b0, vr}, 3'd1);
    endtask

    initial begin
        logic [63:0] junk;
        logic [2:0]  held;
        junk = 64'h9E37_79B9_7F4A_7C15;
        // R4: reset state
        repeat (3) @(negedge clk);
        check("R4", hr, 3'b100);
        check("R4", {2'b0, vr}, 3'd0);
        rst_n = 1'b1;

        // R1: first pair alone, including value 3 folding to residue zero
        for (int v = 0; v < 4; v++) begin
            apply(2'(v), 2'd0, 2'd0, 2'd0, 64'd0, "R1");
        end

        // R2 / R7 / R8: full sweep with changing junk in unused bits
        for (int i = 0; i < 256; i++) begin
            junk = {junk[62:0], junk[63] ^ junk[62] ^ junk[60] ^ junk[59]} ^ 64'(i * 7919);
            apply(2'(i), 2'(i >> 2), 2'(i >> 4), 2'(i >> 6), junk, (i % 2 == 0) ? "R2" : "R7");
        end

        // R5: hold while idle even as inputs change; R3: valid drops
        apply(2'd1, 2'd0, 2'd0, 2'd0, 64'd0, "R2");
        held = hr;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_addr  = {in_addr[62:0], ~in_addr[63]} ^ (64'h1 << (15 + k));
            in_msb   = 2'(k + 1);
            @(negedge clk);
            check("R5", hr, held);
            check("R3", {2'b0, vr}, 3'd0);
        end

        // R6: one-hot after a final strobe
        apply(2'd3, 2'd3, 2'd3, 2'd3, '1, "R6");
        check("R6", 3'($countones(hr)), 3'd1);

        // R4: reset again clears a non-zero hash
        apply(2'd2, 2'd0, 2'd0, 2'd0, 64'd0, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R4", hr, 3'b100);
        check("R4", {2'b0, vl}, 3'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule